// File: doc/BRIEF.md
# Double-Index DMA Address Generator

This block produces the byte address sequence for one side (source or destination) of a DMA channel's block transfer. A block is made of a programmed number of frames, and every frame is made of a programmed number of elements. Two signed 16-bit strides shape the walk through memory:

- The element stride applies between neighbouring elements of one frame.
- The frame stride applies when moving from the last element of a frame to the first element of the next.

A negative frame stride can bring every frame back to one fixed address, which suits a peripheral port read repeatedly into a memory buffer.

The consumer (a bus engine) takes the current address whenever `ready` and `step` are both high. The generator then moves on to the next element. In free-running mode, frames follow each other with no further condition. In triggered mode, each trigger pulse releases exactly one frame. Triggers that arrive while a frame is still open are counted and are not lost. `eof` and `eob` qualify the step that ends a frame or the block. The current element and frame positions are visible all the time.

Top module: `dix_addr_gen`

## Requirements
- R1: After a synchronous reset the outputs are idle: `busy`=0, `ready`=0, `addr`=0, `cur_elem`=0, `cur_frame`=0. `ready` is never high while `busy` is low.
- R2: A `start` pulse captures the whole configuration. In the next cycle `busy`=1, `addr`=`cfg_base`, `cur_elem`=0 and `cur_frame`=0. Both counts must be at least 1. `start` takes priority over a step in the same cycle.
- R3: A step taken on an element that is not the last of its frame moves the address to addr + S + element_stride − 1, where S = 1 << `cfg_esize` bytes (0:1, 1:2, 2:4, 3:8). It also increments `cur_elem`.
- R4: A step taken on the last element of a frame that is not the last frame uses the frame stride in place of the element stride. It clears `cur_elem`, increments `cur_frame`, and raises `eof` in that same cycle.
- R5: Both strides are 16-bit two's-complement, and address arithmetic wraps modulo 2^32. With S=1, element stride 1 and frame stride −(N−1), every N-element frame starts at `cfg_base`. This must hold for N=4096.
- R6: The final step of the block raises `eob` together with `eof` in that cycle. `busy` then falls. `addr`, `cur_elem` and `cur_frame` hold their values, and later steps change nothing until the next `start`.
- R7: In free-running mode (`cfg_hw_sync`=0), `ready` is high for the whole time `busy` is high.
- R8: In triggered mode (`cfg_hw_sync`=1), `ready` rises one cycle after a trigger is taken. It stays high for exactly one frame of elements and falls after the step that ends that frame, unless another trigger is pending.
- R9: Triggers that arrive while a frame is open, or in bursts, are queued (up to 2^PEND_W−1) and each releases one later frame. Triggers are ignored while idle or in free-running mode, and `start` clears the queue.
- R10: A `step` while `ready` is low leaves `addr`, `cur_elem` and `cur_frame` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: capture configuration and begin a block |
| cfg_base | input | AW | Start byte address |
| cfg_esize | input | 2 | Element size code, bytes = 1 << code |
| cfg_elem_cnt | input | ECNT_W | Elements per frame (≥1) |
| cfg_frame_cnt | input | FCNT_W | Frames per block (≥1) |
| cfg_elem_idx | input | IDX_W | Signed element stride |
| cfg_frame_idx | input | IDX_W | Signed frame stride |
| cfg_hw_sync | input | 1 | 1: one frame per trigger, 0: free-running |
| trig | input | 1 | Frame release event (triggered mode) |
| step | input | 1 | Consumer takes the current address |
| addr | output | AW | Current element address |
| ready | output | 1 | Current address may be taken |
| busy | output | 1 | Block in progress |
| eof | output | 1 | Accepted step is the last of its frame |
| eob | output | 1 | Accepted step is the last of the block |
| cur_elem | output | ECNT_W | Element position within the frame |
| cur_frame | output | FCNT_W | Frame position within the block |

## Verification
The configurations used each isolate one part of the address arithmetic:

- A contiguous walk with 4-byte elements exposes any error in the size term.
- A positive gap stride with a separate large frame stride shows whether the two strides are kept apart at the frame boundary.
- A rewinding byte walk with N=4096 separates correct sign handling from zero-extension.
- Single-element frames show that only the frame stride is used.
- Negative strides that cross below address zero prove the modulo-2^32 wrap.

Triggered runs use spaced single triggers to show that one trigger opens exactly one frame. Back-to-back trigger bursts show that queued events are not lost. A step held constantly high against a closed frame shows that the ignored steps truly leave the state alone. Step patterns with gaps tell the handshake qualification apart from free stepping.

// File: rtl/dix_pkg.sv
package dix_pkg;

  typedef enum logic [1:0] {
    ESZ_1B = 2'd0,
    ESZ_2B = 2'd1,
    ESZ_4B = 2'd2,
    ESZ_8B = 2'd3
  } esize_t;

  function automatic logic [3:0] esize_bytes(esize_t e);
    return 4'd1 << e;
  endfunction

endpackage

// File: rtl/dix_step_ctr.sv
module dix_step_ctr #(
  parameter int ECNT_W = 16,
  parameter int FCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  input  logic [ECNT_W-1:0] elem_last_pos,
  input  logic [FCNT_W-1:0] frame_last_pos,
  output logic [ECNT_W-1:0] cur_elem,
  output logic [FCNT_W-1:0] cur_frame,
  output logic              at_last_elem,
  output logic              at_last_frame
);

  logic [ECNT_W-1:0] elem_q;
  logic [FCNT_W-1:0] frame_q;

  assign at_last_elem  = (elem_q == elem_last_pos);
  assign at_last_frame = (frame_q == frame_last_pos);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      elem_q  <= '0;
      frame_q <= '0;
    end else if (adv && !(at_last_elem && at_last_frame)) begin
      if (at_last_elem) begin
        elem_q  <= '0;
        frame_q <= frame_q + 1'b1;
      end else begin
        elem_q  <= elem_q + 1'b1;
      end
    end
  end

  assign cur_elem  = elem_q;
  assign cur_frame = frame_q;

endmodule

// File: rtl/dix_addr_unit.sv
module dix_addr_unit
  import dix_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic             adv,
  input  logic             use_frame_idx,
  input  logic             hold,
  input  esize_t           esize,
  input  logic [IDX_W-1:0] elem_idx,
  input  logic [IDX_W-1:0] frame_idx,
  output logic [AW-1:0]    addr
);

  localparam int EXT_W = AW - IDX_W;

  logic [IDX_W-1:0] sel_idx;
  logic [AW-1:0]    idx_ext;
  logic [AW-1:0]    size_ext;
  logic [AW-1:0]    next_addr;
  logic [AW-1:0]    addr_q;

  assign sel_idx   = use_frame_idx ? frame_idx : elem_idx;
  assign idx_ext   = {{EXT_W{sel_idx[IDX_W-1]}}, sel_idx};
  assign size_ext  = {{(AW-4){1'b0}}, esize_bytes(esize)};
  assign next_addr = addr_q + size_ext + idx_ext - {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_addr;
    end else if (adv && !hold) begin
      addr_q <= next_addr;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/dix_frame_gate.sv
module dix_frame_gate #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic busy,
  input  logic hw_mode,
  input  logic trig,
  input  logic frame_done,
  input  logic block_done,
  output logic frame_open
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend_q;
  logic [PEND_W:0]   pend_sum;
  logic              open_q;
  logic              trig_in;
  logic              inc;
  logic              take;

  assign trig_in = trig && busy && hw_mode && !clear;
  assign take    = busy && hw_mode && !clear &&
                   (!open_q || (frame_done && !block_done)) &&
                   ((pend_q != '0) || trig_in);
  assign inc      = trig_in && ((pend_q != PEND_MAX) || take);
  assign pend_sum = {1'b0, pend_q} + {{PEND_W{1'b0}}, inc}
                    - {{PEND_W{1'b0}}, take};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend_q <= '0;
      open_q <= 1'b0;
    end else begin
      pend_q <= pend_sum[PEND_W-1:0];
      if (frame_done) begin
        open_q <= take;
      end else if (take) begin
        open_q <= 1'b1;
      end
    end
  end

  assign frame_open = open_q;

endmodule

// File: rtl/dix_addr_gen.sv
module dix_addr_gen
  import dix_pkg::*;
#(
  parameter int AW     = 32,
  parameter int ECNT_W = 16,
  parameter int FCNT_W = 16,
  parameter int IDX_W  = 16,
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     cfg_base,
  input  logic [1:0]        cfg_esize,
  input  logic [ECNT_W-1:0] cfg_elem_cnt,
  input  logic [FCNT_W-1:0] cfg_frame_cnt,
  input  logic [IDX_W-1:0]  cfg_elem_idx,
  input  logic [IDX_W-1:0]  cfg_frame_idx,
  input  logic              cfg_hw_sync,
  input  logic              trig,
  input  logic              step,
  output logic [AW-1:0]     addr,
  output logic              ready,
  output logic              busy,
  output logic              eof,
  output logic              eob,
  output logic [ECNT_W-1:0] cur_elem,
  output logic [FCNT_W-1:0] cur_frame
);

  logic              busy_q;
  logic              hw_q;
  esize_t            esize_q;
  logic [ECNT_W-1:0] elast_q;
  logic [FCNT_W-1:0] flast_q;
  logic [IDX_W-1:0]  eidx_q;
  logic [IDX_W-1:0]  fidx_q;

  logic accept;
  logic last_e;
  logic last_f;
  logic frame_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      hw_q    <= 1'b0;
      esize_q <= ESZ_1B;
      elast_q <= '0;
      flast_q <= '0;
      eidx_q  <= '0;
      fidx_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      hw_q    <= cfg_hw_sync;
      esize_q <= esize_t'(cfg_esize);
      elast_q <= cfg_elem_cnt - 1'b1;
      flast_q <= cfg_frame_cnt - 1'b1;
      eidx_q  <= cfg_elem_idx;
      fidx_q  <= cfg_frame_idx;
    end else if (accept && last_e && last_f) begin
      busy_q  <= 1'b0;
    end
  end

  assign ready  = busy_q && (!hw_q || frame_open);
  assign accept = step && ready && !start;

  dix_step_ctr #(
    .ECNT_W(ECNT_W),
    .FCNT_W(FCNT_W)
  ) ctr_i (
    .clk           (clk),
    .rst           (rst),
    .clear         (start),
    .adv           (accept),
    .elem_last_pos (elast_q),
    .frame_last_pos(flast_q),
    .cur_elem      (cur_elem),
    .cur_frame     (cur_frame),
    .at_last_elem  (last_e),
    .at_last_frame (last_f)
  );

  dix_addr_unit #(
    .AW   (AW),
    .IDX_W(IDX_W)
  ) addr_i (
    .clk          (clk),
    .rst          (rst),
    .load         (start),
    .load_addr    (cfg_base),
    .adv          (accept),
    .use_frame_idx(last_e),
    .hold         (last_e && last_f),
    .esize        (esize_q),
    .elem_idx     (eidx_q),
    .frame_idx    (fidx_q),
    .addr         (addr)
  );

  dix_frame_gate #(
    .PEND_W(PEND_W)
  ) gate_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (start),
    .busy      (busy_q),
    .hw_mode   (hw_q),
    .trig      (trig),
    .frame_done(accept && last_e),
    .block_done(accept && last_e && last_f),
    .frame_open(frame_open)
  );

  assign busy = busy_q;
  assign eof  = accept && last_e;
  assign eob  = accept && last_e && last_f;

endmodule

// File: rtl/dix_addr_gen_chk.sv
module dix_addr_gen_chk #(
  parameter int AW     = 32,
  parameter int ECNT_W = 16,
  parameter int FCNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              step,
  input logic              ready,
  input logic              busy,
  input logic              eof,
  input logic              eob,
  input logic              hw_mode,
  input logic [AW-1:0]     addr,
  input logic [ECNT_W-1:0] cur_elem,
  input logic [FCNT_W-1:0] cur_frame
);

  // R1
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ready);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && cur_elem == '0 && cur_frame == '0));

  // R3
  elem_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (step && ready && !start && !eof) |=>
      (cur_elem == $past(cur_elem) + 1'b1 && $stable(cur_frame)));

  // R4
  frame_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (eof && !eob) |=> (cur_elem == '0 && cur_frame == $past(cur_frame) + 1'b1));

  // R6
  eob_with_eof_chk: assert property (@(posedge clk) disable iff (rst)
    eob |-> eof);

  // R6
  eob_ends_chk: assert property (@(posedge clk) disable iff (rst)
    eob |=> (!busy && $stable(addr) && $stable(cur_elem) && $stable(cur_frame)));

  // R7
  free_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !hw_mode) |-> ready);

  // R10
  no_step_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ((!ready || !step) && !start) |=>
      ($stable(addr) && $stable(cur_elem) && $stable(cur_frame)));

endmodule

bind dix_addr_gen dix_addr_gen_chk #(
  .AW    (AW),
  .ECNT_W(ECNT_W),
  .FCNT_W(FCNT_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .step     (step),
  .ready    (ready),
  .busy     (busy),
  .eof      (eof),
  .eob      (eob),
  .hw_mode  (hw_q),
  .addr     (addr),
  .cur_elem (cur_elem),
  .cur_frame(cur_frame)
);

// File: tb/dix_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dix_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [1:0]  cfg_esize = '0;
  logic [15:0] cfg_elem_cnt = 16'd1;
  logic [15:0] cfg_frame_cnt = 16'd1;
  logic [15:0] cfg_elem_idx = '0;
  logic [15:0] cfg_frame_idx = '0;
  logic        cfg_hw_sync = 1'b0;
  logic        trig = 1'b0;
  logic        step = 1'b0;
  logic [31:0] addr;
  logic        ready, busy, eof, eob;
  logic [15:0] cur_elem, cur_frame;

  always #2.5 clk = ~clk;

  dix_addr_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base),
    .cfg_esize(cfg_esize), .cfg_elem_cnt(cfg_elem_cnt),
    .cfg_frame_cnt(cfg_frame_cnt), .cfg_elem_idx(cfg_elem_idx),
    .cfg_frame_idx(cfg_frame_idx), .cfg_hw_sync(cfg_hw_sync),
    .trig(trig), .step(step), .addr(addr), .ready(ready), .busy(busy),
    .eof(eof), .eob(eob), .cur_elem(cur_elem), .cur_frame(cur_frame)
  );

  int    checks = 0;
  int    errors = 0;
  string req = "R1";
  bit    cmp_en = 1'b0;
  bit    rw_chk = 1'b0;
  logic [31:0] rw_base = '0;
  int    eob_cnt = 0;
  int    cyc = 0;

  // behavioural reference state
  logic        m_busy = 1'b0, m_open = 1'b0, m_hw = 1'b0;
  logic [31:0] m_addr = '0;
  int m_elem = 0, m_frame = 0, m_pend = 0;
  int m_es = 0, m_ecnt = 1, m_fcnt = 1, m_eidx = 0, m_fidx = 0;

  function automatic bit m_ready();
    return m_busy && (!m_hw || m_open);
  endfunction

  task automatic chk(string r, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit acc, le, lf, tin, take;
    if (rst) begin
      m_busy = 0; m_open = 0; m_hw = 0; m_addr = 0;
      m_elem = 0; m_frame = 0; m_pend = 0;
    end else if (start) begin
      m_busy = 1; m_open = 0; m_pend = 0; m_hw = cfg_hw_sync;
      m_addr = cfg_base; m_elem = 0; m_frame = 0;
      m_es = cfg_esize; m_ecnt = cfg_elem_cnt; m_fcnt = cfg_frame_cnt;
      m_eidx = $signed(cfg_elem_idx); m_fidx = $signed(cfg_frame_idx);
    end else begin
      acc  = step && m_ready();
      le   = (m_elem == m_ecnt - 1);
      lf   = (m_frame == m_fcnt - 1);
      tin  = trig && m_busy && m_hw;
      take = m_busy && m_hw && (!m_open || (acc && le && !lf)) &&
             (m_pend > 0 || tin);
      m_pend = m_pend + int'(tin) - int'(take);
      if (acc && le) m_open = take;
      else if (take) m_open = 1;
      if (acc) begin
        if (le && lf) m_busy = 0;
        else if (le) begin
          m_addr = m_addr + (32'd1 << m_es) + m_fidx - 1;
          m_elem = 0; m_frame++;
        end else begin
          m_addr = m_addr + (32'd1 << m_es) + m_eidx - 1;
          m_elem++;
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    bit e_rdy, e_eof, e_eob;
    if (cmp_en) begin
      e_rdy = m_ready();
      e_eof = step && e_rdy && !start && (m_elem == m_ecnt - 1);
      e_eob = e_eof && (m_frame == m_fcnt - 1);
      chk(req, "busy", busy, m_busy);
      chk(req, "ready", ready, e_rdy);
      chk(req, "addr", addr, m_addr);
      chk(req, "cur_elem", cur_elem, m_elem);
      chk(req, "cur_frame", cur_frame, m_frame);
      chk(req, "eof", eof, e_eof);
      chk(req, "eob", eob, e_eob);
      if (eob) eob_cnt++;
      if (rw_chk && busy && cur_elem == 0) chk("R5", "frame start addr", addr, rw_base);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_blk(string tag, logic [31:0] base, int es, int ec, int fc,
                         int ei, int fi, bit hw, int tmode, int spat, bit rw);
    int k;
    req = tag;
    @(posedge clk); #1;
    cfg_base = base; cfg_esize = es[1:0];
    cfg_elem_cnt = ec[15:0]; cfg_frame_cnt = fc[15:0];
    cfg_elem_idx = ei[15:0]; cfg_frame_idx = fi[15:0];
    cfg_hw_sync = hw; start = 1; step = 0; trig = 0;
    eob_cnt = 0; rw_base = base;
    @(posedge clk); #1;
    start = 0; rw_chk = rw;
    chk("R2", "addr after start", addr, base);
    chk("R2", "busy after start", busy, 1);
    k = 0;
    while (m_busy && k < 40000) begin
      step = (spat == 0) ? 1'b1 : ((k % 4) != 3);
      if (hw && tmode == 1) trig = (k < fc);
      else if (hw && tmode == 2) trig = ((k % 40) == 0);
      else trig = 0;
      @(posedge clk); #1;
      k++;
    end
    trig = 0;
    step = 1;
    repeat (4) @(posedge clk);
    #1;
    step = 0;
    rw_chk = 0;
    chk("R6", "eob pulses per block", eob_cnt, 1);
    chk("R6", "busy after block", busy, 0);
    chk(tag, "block completed in time", k < 40000, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    cmp_en = 1;
    chk("R1", "busy", busy, 0);
    chk("R1", "ready", ready, 0);
    chk("R1", "addr", addr, 0);
    chk("R1", "cur_elem", cur_elem, 0);
    repeat (2) @(posedge clk);
    #1;
    run_blk("R3", 32'h0000_1000, 2, 5, 3, 1, 1, 0, 0, 1, 0);
    run_blk("R4", 32'h0000_2000, 1, 4, 4, 5, 100, 0, 0, 0, 0);
    run_blk("R5", 32'h0000_0300, 0, 8, 4, 1, -7, 0, 0, 1, 1);
    run_blk("R5", 32'h0000_0008, 2, 3, 3, -15, -31, 0, 0, 0, 0);
    run_blk("R5", 32'h8000_0000, 0, 4096, 3, 1, -4095, 0, 0, 0, 1);
    run_blk("R7", 32'h0000_0040, 3, 1, 5, 0, 9, 0, 0, 1, 0);
    run_blk("R8", 32'h0000_4000, 0, 6, 3, 1, 1, 1, 2, 0, 0);
    run_blk("R9", 32'h0000_5000, 1, 4, 5, 1, 3, 1, 1, 1, 0);
    run_blk("R10", 32'h0000_6000, 2, 3, 3, 1, 1, 1, 2, 0, 0);
    // R9: triggers while idle must not release a frame in the next block
    req = "R9";
    @(posedge clk); #1;
    trig = 1;
    repeat (3) @(posedge clk);
    #1;
    trig = 0;
    cfg_hw_sync = 1; start = 1;
    @(posedge clk); #1;
    start = 0; step = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "ready without trigger", ready, 0);
    chk("R10", "addr held with closed frame", addr, cfg_base);
    step = 0;
    cmp_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule